// File: doc/BRIEF.md
# Multichannel Threshold Spike Reporter

This block sits behind the converters of a many-channel neural recording front end. Samples arrive one at a time on a time-multiplexed bus, each tagged with its channel number. Every channel has its own signed threshold, and a channel counts as spiking when its sample rises above that level. The block never forwards waveforms. It only records which channels produced a spike, so the outgoing data rate follows spike activity rather than the channel count.

The address of each new spike goes into a small queue. When the sample for the highest-numbered channel has been processed, one scan is complete and a frame is scheduled. The frame carries a synchronization word, a flag that shows whether addresses were lost, every queued address with an even-parity bit, and an end marker. A downstream transmitter pulls the frame out one bit at a time with an enable strobe. The default build serves 100 channels with 7-bit addresses.

Top module: `spike_reporter`

## Requirements
- R1: Each channel's signed threshold is written through `cfg_we`/`cfg_chan`/`cfg_thr` and holds until it is rewritten. A sample is a spike candidate only when it is strictly greater than its channel's threshold, so a sample equal to the threshold is not a candidate.
- R2: A channel reports once per crossing. After it reports, it stays disarmed until one of its samples is less than or equal to its threshold. All channels are armed after reset.
- R3: Exactly one frame is scheduled for each processed sample of channel `NUM_CH-1`. The frame is sent even when it holds no addresses. No frame starts before that sample.
- R4: A frame is, MSB first: the `SYNC_W`-bit `SYNC_WORD`, one overflow bit, zero or more address entries, and an end marker. The end marker is an address field of all ones followed by that field's even-parity bit. `ser_valid` drops only after the last bit of the end marker.
- R5: An entry is the `ADDR_W`-bit channel address, MSB first, followed by one parity bit. The parity bit makes the count of ones across the address and parity bit even.
- R6: Entries appear in the order the spikes were detected. Within one in-order scan, that is ascending channel number.
- R7: The queue holds `FIFO_DEPTH` addresses. A spike that arrives while the queue is full is dropped and sets a sticky overflow flag. The next frame header carries the flag as 1, and the flag then clears.
- R8: `ser_valid` stays high for a whole frame. `ser_data` moves to the next bit only in a cycle where `bit_en` is high, and otherwise holds its value.
- R9: After reset, `ser_valid` is low, the queue is empty, no frame is pending and the overflow flag is clear.
- R10: A sample presented while `smp_valid` is low has no effect. It neither queues an address nor ends a scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | ADDR_W | Channel number of the sample |
| smp_data | input | SAMP_W | Signed sample value |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_chan | input | ADDR_W | Channel whose threshold is written |
| cfg_thr | input | SAMP_W | Signed threshold value |
| bit_en | input | 1 | Consumes the current serial bit |
| ser_data | output | 1 | Current serial bit |
| ser_valid | output | 1 | High while a frame is being sent |

## Verification
A sample takes two register stages to become a queued address or a scan-end event. The frame header then appears on `ser_valid` three cycles after the last channel's sample is taken. The bench therefore waits for `ser_valid` with a bounded search and does not count cycles open-loop. Once a frame is live, each bit lands one cycle after the `bit_en` that consumes the previous bit. The bench drives `bit_en` and reads `ser_data` at the falling edge, holding the strobe low for stretches, so every bit is taken from the half-cycle before the edge that consumes it. Queue contents and the overflow flag are fixed when a frame starts, so the bench drains each frame completely before it feeds the next scan.

// File: rtl/spike_pkg.sv
package spike_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_HDR  = 2'd1,
    FR_ENT  = 2'd2,
    FR_END  = 2'd3
  } frame_state_t;
endpackage

// File: rtl/spike_detect.sv
module spike_detect #(
  parameter int NUM_CH = 100,
  parameter int ADDR_W = 7,
  parameter int SAMP_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic [ADDR_W-1:0]        smp_chan,
  input  logic signed [SAMP_W-1:0] smp_data,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_chan,
  input  logic signed [SAMP_W-1:0] cfg_thr,
  output logic                     push,
  output logic [ADDR_W-1:0]        push_addr,
  output logic                     scan_end
);
  localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(NUM_CH - 1);

  logic signed [SAMP_W-1:0] thr_mem [NUM_CH];
  logic signed [SAMP_W-1:0] thr_rd;
  logic signed [SAMP_W-1:0] s1_data;
  logic [ADDR_W-1:0]        s1_chan;
  logic                     s1_valid;
  logic [NUM_CH-1:0]        armed;
  logic                     above;

  // threshold store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (cfg_we && cfg_chan <= LAST_CH) thr_mem[cfg_chan] <= cfg_thr;
    thr_rd  <= thr_mem[smp_chan];
    s1_data <= smp_data;
    s1_chan <= smp_chan;
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= smp_valid && (smp_chan <= LAST_CH);
  end

  assign above = s1_data > thr_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= '1;
      push      <= 1'b0;
      scan_end  <= 1'b0;
      push_addr <= '0;
    end else begin
      push      <= s1_valid && above && armed[s1_chan];
      push_addr <= s1_chan;
      scan_end  <= s1_valid && (s1_chan == LAST_CH);
      if (s1_valid) armed[s1_chan] <= !above;
    end
  end

  assert_single_report_R2: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && above && !armed[s1_chan]) |=> !push);
endmodule

// File: rtl/spike_fifo.sv
module spike_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 7,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              full, do_push, do_pop;

  assign full    = count == CNT_W'(DEPTH);
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign drop    = push && full;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == $past(count)));
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/spike_framer.sv
module spike_framer
  import spike_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter int          FIFO_DEPTH = 8,
  parameter int          SYNC_W     = 8,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hB2,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_end,
  input  logic              drop,
  input  logic [CNT_W-1:0]  q_count,
  input  logic [ADDR_W-1:0] q_head,
  input  logic              bit_en,
  output logic              pop,
  output logic              ser_data,
  output logic              ser_valid
);
  localparam int HDR_W = SYNC_W + 1;
  localparam int ENT_W = ADDR_W + 1;
  localparam int SH_W  = (HDR_W > ENT_W) ? HDR_W : ENT_W;
  localparam int BL_W  = $clog2(SH_W + 1);
  localparam logic [ADDR_W-1:0] END_ADDR = '1;

  frame_state_t      state;
  logic [SH_W-1:0]   sh;
  logic [BL_W-1:0]   bits_left;
  logic [CNT_W-1:0]  ent_left;
  logic              req_q, ovf_q, start, seg_done;

  assign start    = (state == FR_IDLE) && req_q;
  assign seg_done = (state != FR_IDLE) && bit_en && (bits_left == BL_W'(1));
  assign pop      = seg_done && (state != FR_END) && (ent_left != '0);
  assign ser_data  = sh[SH_W-1];
  assign ser_valid = state != FR_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      req_q <= scan_end || (req_q && !start);
      ovf_q <= drop || (ovf_q && !start);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FR_IDLE;
      sh        <= '0;
      bits_left <= '0;
      ent_left  <= '0;
    end else if (start) begin
      state     <= FR_HDR;
      sh        <= SH_W'({SYNC_WORD, ovf_q}) << (SH_W - HDR_W);
      bits_left <= BL_W'(HDR_W);
      ent_left  <= q_count;
    end else if (state != FR_IDLE && bit_en) begin
      if (!seg_done) begin
        sh        <= sh << 1;
        bits_left <= bits_left - 1'b1;
      end else if (pop) begin
        state     <= FR_ENT;
        sh        <= SH_W'({q_head, ^q_head}) << (SH_W - ENT_W);
        bits_left <= BL_W'(ENT_W);
        ent_left  <= ent_left - 1'b1;
      end else if (state != FR_END) begin
        state     <= FR_END;
        sh        <= SH_W'({END_ADDR, ^END_ADDR}) << (SH_W - ENT_W);
        bits_left <= BL_W'(ENT_W);
      end else begin
        state <= FR_IDLE;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && !bit_en) |=> (ser_valid && $stable(ser_data)));
  assert_even_parity_R5: assert property (@(posedge clk) disable iff (rst)
    (state == FR_ENT && bits_left == BL_W'(ENT_W)) |-> ((^sh[SH_W-1 -: ENT_W]) == 1'b0));
  assert_end_last_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_valid) |-> ($past(state) == FR_END));
  assert_scan_frame_R3: assert property (@(posedge clk) disable iff (rst)
    scan_end |=> (req_q || ser_valid));
endmodule

// File: rtl/spike_reporter.sv
module spike_reporter #(
  parameter int NUM_CH     = 100,
  parameter int SAMP_W     = 10,
  parameter int FIFO_DEPTH = 8,
  parameter int SYNC_W     = 8,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hB2,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic [ADDR_W-1:0]        smp_chan,
  input  logic signed [SAMP_W-1:0] smp_data,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_chan,
  input  logic signed [SAMP_W-1:0] cfg_thr,
  input  logic                     bit_en,
  output logic                     ser_data,
  output logic                     ser_valid
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              push, scan_end, pop, drop;
  logic [ADDR_W-1:0] push_addr, q_head;
  logic [CNT_W-1:0]  q_count;

  spike_detect #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_detect (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_thr(cfg_thr),
    .push(push), .push_addr(push_addr), .scan_end(scan_end));

  spike_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(ADDR_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_addr), .pop(pop),
    .head(q_head), .count(q_count), .drop(drop));

  spike_framer #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .SYNC_W(SYNC_W),
                 .SYNC_WORD(SYNC_WORD)) u_framer (
    .clk(clk), .rst(rst), .scan_end(scan_end), .drop(drop), .q_count(q_count),
    .q_head(q_head), .bit_en(bit_en), .pop(pop), .ser_data(ser_data),
    .ser_valid(ser_valid));
endmodule

// File: tb/tb_spike_reporter.sv
module tb_spike_reporter;
  localparam int NCH = 12;
  localparam int SW  = 10;
  localparam int DEP = 4;
  localparam int AW  = 4;
  localparam logic [7:0] SYNC = 8'hB2;

  logic clk = 0, rst = 1;
  logic smp_valid = 0, cfg_we = 0, bit_en = 0;
  logic [AW-1:0] smp_chan = '0, cfg_chan = '0;
  logic signed [SW-1:0] smp_data = '0, cfg_thr = '0;
  logic ser_data, ser_valid;

  spike_reporter #(.NUM_CH(NCH), .SAMP_W(SW), .FIFO_DEPTH(DEP), .SYNC_W(8),
                   .SYNC_WORD(SYNC)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_thr(cfg_thr),
    .bit_en(bit_en), .ser_data(ser_data), .ser_valid(ser_valid));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int thr [NCH];
  bit armed [NCH];
  int samp [NCH];
  int exp_addr [16];
  int exp_n;
  bit exp_ovf;
  bit rx [256];
  int nbits;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic write_thr(input int ch, input int v);
    @(negedge clk);
    cfg_we = 1; cfg_chan = AW'(ch); cfg_thr = SW'(v);
    thr[ch] = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // feeds samp[0..NCH-1] in order and builds the expected frame
  task automatic run_scan();
    exp_n = 0; exp_ovf = 0;
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      smp_valid = 1; smp_chan = AW'(c); smp_data = SW'(samp[c]);
      if (samp[c] > thr[c]) begin
        if (armed[c]) begin
          if (exp_n < DEP) begin exp_addr[exp_n] = c; exp_n++; end
          else exp_ovf = 1;
        end
        armed[c] = 0;
      end else armed[c] = 1;
    end
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic recv_frame(input int hold);
    int w = 0;
    int ph = 0;
    nbits = 0;
    while (!ser_valid && w < 60) begin @(negedge clk); w++; end
    check(ser_valid, "R3 frame appears after scan end", ser_valid, 1);
    for (int h = 0; h < hold; h++) begin
      bit_en = 0;
      @(negedge clk);
      check(ser_valid && ser_data == SYNC[7], "R8 hold without bit_en", ser_data, SYNC[7]);
    end
    while (ser_valid && nbits < 256) begin
      bit_en = (ph % 3) != 2;
      ph++;
      if (bit_en) begin rx[nbits] = ser_data; nbits++; end
      @(negedge clk);
    end
    bit_en = 0;
  endtask

  task automatic verify_frame(input string tag);
    int pos, a, n;
    bit p, ended;
    int sy = 0;
    for (int i = 0; i < 8; i++) sy = (sy << 1) | rx[i];
    check(sy == SYNC, {"R4 sync word ", tag}, sy, SYNC);
    check(rx[8] == exp_ovf, {"R7 overflow bit ", tag}, rx[8], exp_ovf);
    pos = 9; n = 0; ended = 0;
    while (pos + AW + 1 <= nbits && !ended) begin
      a = 0;
      for (int i = 0; i < AW; i++) a = (a << 1) | rx[pos + i];
      p = rx[pos + AW];
      check((^AW'(a)) == p, {"R5 even parity ", tag}, p, ^AW'(a));
      pos += AW + 1;
      if (a == (1 << AW) - 1) ended = 1;
      else begin
        if (n < 16) check(n < exp_n && a == exp_addr[n], {"R6 entry address ", tag}, a,
                          (n < exp_n) ? exp_addr[n] : -1);
        n++;
      end
    end
    check(ended && pos == nbits, {"R4 end marker closes frame ", tag}, pos, nbits);
    check(n == exp_n, {"R1 spike count ", tag}, n, exp_n);
  endtask

  task automatic scan_and_check(input string tag);
    run_scan();
    recv_frame(0);
    verify_frame(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) armed[c] = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!ser_valid, "R9 idle after reset", ser_valid, 0);
    for (int c = 0; c < NCH; c++) write_thr(c, 100);

    // R3: no frame before the last channel, empty frame after it
    for (int c = 0; c < NCH; c++) samp[c] = 0;
    for (int c = 0; c < NCH - 1; c++) begin
      @(negedge clk); smp_valid = 1; smp_chan = AW'(c); smp_data = '0;
    end
    @(negedge clk); smp_valid = 0;
    repeat (10) @(negedge clk);
    check(!ser_valid, "R3 no frame mid scan", ser_valid, 0);
    run_scan();
    recv_frame(0);
    verify_frame("partial+full");
    // the scan above holds one extra partial pass; expected was reset by run_scan

    // R1/R6 plus R8 hold
    for (int c = 0; c < NCH; c++) samp[c] = 0;
    samp[2] = 150; samp[5] = 150; samp[9] = 150;
    run_scan(); recv_frame(4); verify_frame("three spikes");

    // R2: still above -> no report; R1: equal is not a spike
    samp[5] = 0; samp[7] = 100;
    scan_and_check("no rearm");
    samp[2] = 0; samp[5] = 150;
    scan_and_check("rearm ch5");

    // R1: signed thresholds
    write_thr(3, -50); write_thr(4, -50);
    for (int c = 0; c < NCH; c++) samp[c] = 0;
    samp[3] = -40; samp[4] = -50;
    scan_and_check("negative thr");

    // R7: overflow then clear
    for (int c = 0; c < NCH; c++) samp[c] = 200;
    scan_and_check("overflow");
    check(exp_ovf == 1, "R7 scenario overflows", exp_ovf, 1);
    for (int c = 0; c < NCH; c++) samp[c] = -300;
    scan_and_check("overflow cleared");

    // R10: invalid samples ignored
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk); smp_valid = 0; smp_chan = AW'(c); smp_data = SW'(400);
    end
    repeat (15) @(negedge clk);
    check(!ser_valid, "R10 invalid samples end no scan", ser_valid, 0);
    for (int c = 0; c < NCH; c++) samp[c] = -300;
    scan_and_check("after invalid");

    // sweep of random thresholds and samples
    for (int s = 0; s < 40; s++) begin
      if (s % 5 == 0)
        for (int c = 0; c < NCH; c++) write_thr(c, $urandom_range(400) - 200);
      for (int c = 0; c < NCH; c++) samp[c] = $urandom_range(600) - 300;
      scan_and_check("sweep");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule